// File: doc/BRIEF.md
# USB Host Root-Port Status and Control Register

This block holds the low seven bits of the status and control word for one root-hub port of a USB 2.0 host. Software reads the whole word at any time and writes it as a full 32-bit word under a single strobe. Each write acts on the bits as follows:

- **Change bits:** a 1 in a change-bit position clears that bit.
- **Enable bit:** a 0 in the enable position disables the port.
- **Resume bit:** the resume position either starts or ends resume signalling.

Hardware event inputs feed the block: device presence, a J-to-K resume detection while suspended, overcurrent sensing, a port error sampled at the end-of-frame check point, completion of the reset-and-enable sequence, and a flag that the port has reached high-speed idle.

The block produces the read word, the port-enabled state and the resume drive level. It also produces a one-cycle pulse toward the controller-wide port-change status. This pulse fires only when hardware, not software, starts a resume.

Every status bit is registered. An input seen at a rising clock edge is visible on `rd_data` after that edge. Reset is synchronous and active low.

Top module: `usbp_port_status`

## Requirements
- R1: After reset the read word is 0x0000_0004 (only the enable bit set), `drive_resume` and `port_change_pulse` are 0, and read bits 31..7 are always 0.
- R2: Bit 0 shows `dev_present` as sampled at the previous clock edge; writes have no effect on it.
- R3: Bit 1 is set after every edge at which `dev_present` differs from bit 0, and stays set while already set. A write with bit 1 = 1 clears it; a write with bit 1 = 0 leaves it unchanged.
- R4: Bit 2 (also `port_enabled`) is never set by a write. It is set only by `enable_done`. It is cleared by a write with bit 2 = 0, by a disconnect (bit 0 was 1 and `dev_present` is 0), by `oc_sense`, or by `eof_error` while enabled. Clearing wins over `enable_done`.
- R5: Bit 3 is set only when `eof_error` arrives while bit 2 is 1. It is not set by enabling or by a disconnect. A write with bit 3 = 1 clears it.
- R6: Bit 4 shows `oc_sense` as sampled at the previous edge. Whenever bit 4 is 1, bit 2 is 0, even if `enable_done` is asserted.
- R7: Bit 5 is set after every edge at which `oc_sense` differs from bit 4. A write with bit 5 = 1 clears it.
- R8: When a set event and a write-one-to-clear of the same change bit (1, 3 or 5) occur in the same cycle, the bit ends up 1.
- R9: `jk_detect` with `suspended` high while bit 6 is 0 sets bit 6 and raises `port_change_pulse` for exactly one cycle, in the same cycle that bit 6 first reads 1. `jk_detect` without `suspended` has no effect.
- R10: A write with bit 6 = 1 sets bit 6 without any `port_change_pulse`.
- R11: `drive_resume` equals bit 6. After a write with bit 6 = 0 while bit 6 is 1, the bit stays 1 until a later cycle with `hs_idle` high, and clears after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for a full word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| dev_present | input | 1 | A device is attached to the port |
| jk_detect | input | 1 | J-to-K transition detected on the line |
| suspended | input | 1 | The port is in the suspend state |
| oc_sense | input | 1 | Overcurrent condition present |
| eof_error | input | 1 | Port error found at the end-of-frame check point |
| enable_done | input | 1 | Reset-and-enable sequence completed |
| hs_idle | input | 1 | The port has returned to high-speed idle |
| port_enabled | output | 1 | Port enabled state (bit 2) |
| drive_resume | output | 1 | Drive resume signalling (bit 6) |
| port_change_pulse | output | 1 | One-cycle pulse when hardware starts a resume |

## Verification
Directed sequences cover the following cases:
- A write of 1 to the enable bit, which shows that software cannot enable the port.
- A double toggle of presence before a clear, which shows the change bit is sticky.
- A disconnect compared with an end-of-frame error, which shows that only the error sets the enable-change bit.
- Overcurrent held during `enable_done`.
- A clear written in the same cycle as a new event, which shows that the event wins.
- Hardware compared with software setting of the resume bit, which differ in the pulse.
- A resume clear held for several cycles while high-speed idle is absent.

Random cycles then mix sparse writes, whose enable bit is mostly 1, with all the event inputs at different rates. A reference model written in the bench checks every field each cycle, which finds priority and timing errors that the directed cases do not reach.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
  localparam int NUM_BITS = 7;
  localparam int BIT_CCS  = 0;
  localparam int BIT_PE   = 2;
  localparam int BIT_OCA  = 4;
  localparam int BIT_FPR  = 6;
  localparam int NUM_CHG  = 3;

  // change bits sit at the odd positions 1, 3, 5
  function automatic int chg_pos(input int idx);
    return 2 * idx + 1;
  endfunction

  // sticky write-one-to-clear: a set event beats a clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // enable: any kill condition beats the completion input
  function automatic logic enable_next(input logic q, input logic kill, input logic done);
    return kill ? 1'b0 : (done | q);
  endfunction
endpackage

// File: rtl/usbp_sticky_bit.sv
module usbp_sticky_bit
  import usbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // covers the change bits of R3, R5 and R7
  assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && clr_i) |=> !q_o);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/usbp_enable_ctl.sv
module usbp_enable_ctl
  import usbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic disc_i,
  input  logic oc_i,
  input  logic sw_off_i,
  input  logic eof_err_i,
  input  logic done_i,
  output logic pe_o,
  output logic err_dis_o
);
  logic kill;

  assign err_dis_o = eof_err_i & pe_o;
  assign kill      = disc_i | oc_i | sw_off_i | err_dis_o;

  always_ff @(posedge clk) begin
    if (!rst_n) pe_o <= 1'b1;
    else        pe_o <= enable_next(pe_o, kill, done_i);
  end

  assert_hw_only_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> !$rose(pe_o));
  assert_disc_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disc_i |=> !pe_o);
  assert_err_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_err_i && pe_o) |=> !pe_o);
endmodule

// File: rtl/usbp_resume_ctl.sv
module usbp_resume_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic jk_i,
  input  logic susp_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  input  logic idle_i,
  output logic fpr_o,
  output logic pcd_o
);
  logic pend_q;
  logic hw_det, sw_set, sw_clr, clr_now;

  assign hw_det  = jk_i & susp_i & ~fpr_o;
  assign sw_set  = wr_en_i & wr_bit_i;
  assign sw_clr  = wr_en_i & ~wr_bit_i & fpr_o;
  assign clr_now = pend_q & idle_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpr_o  <= 1'b0;
      pend_q <= 1'b0;
      pcd_o  <= 1'b0;
    end else begin
      fpr_o  <= hw_det | sw_set | (fpr_o & ~clr_now);
      pend_q <= (hw_det | sw_set | clr_now) ? 1'b0 : (sw_clr | pend_q);
      pcd_o  <= hw_det;
    end
  end

  assert_pulse_on_hw_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pcd_o |-> (fpr_o && !$past(fpr_o)));
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pcd_o |=> !pcd_o);
  assert_sw_set_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_bit_i && !(jk_i && susp_i)) |=> !pcd_o);
  assert_hold_until_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fpr_o && !idle_i) |=> fpr_o);
endmodule

// File: rtl/usbp_port_status.sv
module usbp_port_status
  import usbp_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             dev_present,
  input  logic             jk_detect,
  input  logic             suspended,
  input  logic             oc_sense,
  input  logic             eof_error,
  input  logic             enable_done,
  input  logic             hs_idle,
  output logic             port_enabled,
  output logic             drive_resume,
  output logic             port_change_pulse
);
  logic ccs_q, oca_q, pe_q, fpr_q;
  logic conn_evt, disc_evt, oc_evt, err_dis;
  logic [NUM_CHG-1:0] chg_set, chg_clr, chg_q;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:NUM_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccs_q <= 1'b0;
      oca_q <= 1'b0;
    end else begin
      ccs_q <= dev_present;
      oca_q <= oc_sense;
    end
  end

  assign conn_evt = dev_present ^ ccs_q;
  assign disc_evt = ccs_q & ~dev_present;
  assign oc_evt   = oc_sense ^ oca_q;

  usbp_enable_ctl u_enable (
    .clk       (clk),
    .rst_n     (rst_n),
    .disc_i    (disc_evt),
    .oc_i      (oc_sense),
    .sw_off_i  (wr_en & ~wr_data[BIT_PE]),
    .eof_err_i (eof_error),
    .done_i    (enable_done),
    .pe_o      (pe_q),
    .err_dis_o (err_dis)
  );

  assign chg_set = {oc_evt, err_dis, conn_evt};

  for (genvar i = 0; i < NUM_CHG; i++) begin : g_chg
    assign chg_clr[i] = wr_en & wr_data[chg_pos(i)];
    usbp_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (chg_set[i]),
      .clr_i (chg_clr[i]),
      .q_o   (chg_q[i])
    );
  end

  usbp_resume_ctl u_resume (
    .clk      (clk),
    .rst_n    (rst_n),
    .jk_i     (jk_detect),
    .susp_i   (suspended),
    .wr_en_i  (wr_en),
    .wr_bit_i (wr_data[BIT_FPR]),
    .idle_i   (hs_idle),
    .fpr_o    (fpr_q),
    .pcd_o    (port_change_pulse)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_CCS] = ccs_q;
    rd_data[BIT_PE]  = pe_q;
    rd_data[BIT_OCA] = oca_q;
    rd_data[BIT_FPR] = fpr_q;
    for (int k = 0; k < NUM_CHG; k++) rd_data[chg_pos(k)] = chg_q[k];
  end

  assign port_enabled = pe_q;
  assign drive_resume = fpr_q;

  assert_oc_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oca_q |-> !pe_q);
  assert_conn_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conn_evt |=> chg_q[0]);
  assert_oc_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oc_evt |=> chg_q[2]);
endmodule

// File: tb/tb_usbp_port_status.sv
module tb_usbp_port_status;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wr_en, dev_present, jk_detect, suspended, oc_sense;
  logic eof_error, enable_done, hs_idle;
  logic [31:0] wr_data, rd_data;
  logic port_enabled, drive_resume, port_change_pulse;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // reference state
  logic m_ccs, m_csc, m_pe, m_pec, m_oca, m_occ, m_fpr, m_pend, m_pcd;

  usbp_port_status dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dev_present(dev_present), .jk_detect(jk_detect), .suspended(suspended),
    .oc_sense(oc_sense), .eof_error(eof_error), .enable_done(enable_done),
    .hs_idle(hs_idle), .port_enabled(port_enabled), .drive_resume(drive_resume),
    .port_change_pulse(port_change_pulse)
  );

  function automatic logic w1c(input logic q, input logic ev, input logic clr);
    if (ev) return 1'b1;
    return clr ? 1'b0 : q;
  endfunction

  function automatic logic [31:0] model_word();
    return {25'd0, m_fpr, m_occ, m_oca, m_pec, m_pe, m_csc, m_ccs};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 present bit", {31'd0, rd_data[0]}, {31'd0, m_ccs});
    chk("R3 connect change", {31'd0, rd_data[1]}, {31'd0, m_csc});
    chk("R4 enable bit", {31'd0, rd_data[2]}, {31'd0, m_pe});
    chk("R5 enable change", {31'd0, rd_data[3]}, {31'd0, m_pec});
    chk("R6 overcurrent bit", {31'd0, rd_data[4]}, {31'd0, m_oca});
    chk("R7 overcurrent change", {31'd0, rd_data[5]}, {31'd0, m_occ});
    chk("R11 resume bit", {31'd0, rd_data[6]}, {31'd0, m_fpr});
    chk("R1 upper bits", {7'd0, rd_data[31:7]}, 32'd0);
    chk("R4 port_enabled", {31'd0, port_enabled}, {31'd0, m_pe});
    chk("R11 drive_resume", {31'd0, drive_resume}, {31'd0, m_fpr});
    chk("R9 pulse", {31'd0, port_change_pulse}, {31'd0, m_pcd});
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = 32'h4; dev_present = m_ccs; jk_detect = 0;
    eof_error = 0; enable_done = 0; hs_idle = 0;
  endtask

  // one clock: predict from current inputs, advance, compare
  task automatic step();
    logic conn_evt, kill, hw, sset, sclr, clr_now;
    logic n_pe, n_csc, n_pec, n_occ, n_fpr, n_pend;
    conn_evt = dev_present ^ m_ccs;
    kill = (m_ccs & ~dev_present) | oc_sense | (wr_en & ~wr_data[2]) | (eof_error & m_pe);
    n_pe = kill ? 1'b0 : (enable_done | m_pe);
    n_csc = w1c(m_csc, conn_evt, wr_en & wr_data[1]);
    n_pec = w1c(m_pec, eof_error & m_pe, wr_en & wr_data[3]);
    n_occ = w1c(m_occ, oc_sense ^ m_oca, wr_en & wr_data[5]);
    hw = jk_detect & suspended & ~m_fpr;
    sset = wr_en & wr_data[6];
    sclr = wr_en & ~wr_data[6] & m_fpr;
    clr_now = m_pend & hs_idle;
    n_fpr = hw | sset | (m_fpr & ~clr_now);
    n_pend = (hw | sset | clr_now) ? 1'b0 : (sclr | m_pend);
    @(posedge clk);
    @(negedge clk);
    m_pcd = hw; m_ccs = dev_present; m_oca = oc_sense; m_pe = n_pe;
    m_csc = n_csc; m_pec = n_pec; m_occ = n_occ; m_fpr = n_fpr; m_pend = n_pend;
    check_all();
  endtask

  task automatic write(input logic [6:0] v);
    wr_en = 1; wr_data = {25'd0, v};
    step();
    wr_en = 0; wr_data = 32'h4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; wr_en = 0; wr_data = 0; dev_present = 0; jk_detect = 0; suspended = 0;
    oc_sense = 0; eof_error = 0; enable_done = 0; hs_idle = 0;
    m_ccs = 0; m_csc = 0; m_pe = 1; m_pec = 0; m_oca = 0; m_occ = 0;
    m_fpr = 0; m_pend = 0; m_pcd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset word", rd_data, 32'h4);
    chk("R1 reset resume", {31'd0, drive_resume}, 32'd0);
    chk("R1 reset pulse", {31'd0, port_change_pulse}, 32'd0);
    idle_inputs();
    step();

    // R4: software cannot enable
    write(7'h00);
    chk("R4 sw disable", {31'd0, port_enabled}, 32'd0);
    write(7'h04);
    chk("R4 sw write 1 ignored", {31'd0, port_enabled}, 32'd0);
    enable_done = 1; step(); enable_done = 0;
    chk("R4 enable_done sets", {31'd0, port_enabled}, 32'd1);

    // R2/R3: connect, sticky, write 0 no effect, W1C
    dev_present = 1; step();
    chk("R3 connect sets change", rd_data, 32'h7);
    write(7'h05);
    chk("R3 write 0 keeps change", rd_data, 32'h7);
    write(7'h07);
    chk("R3 W1C clears", rd_data, 32'h5);
    dev_present = 0; step(); dev_present = 1; step();
    chk("R3 double toggle sticky", {31'd0, rd_data[1]}, 32'd1);
    // R8: event and clear in same cycle
    dev_present = 0; write(7'h06);
    chk("R8 set beats clear", {31'd0, rd_data[1]}, 32'd1);

    // R5: disconnect does not set enable change
    enable_done = 1; step(); enable_done = 0;
    dev_present = 1; step();
    write(7'h0E);
    dev_present = 0; step();
    chk("R5 disconnect no change bit", {30'd0, rd_data[3:2]}, 32'd0);
    dev_present = 1; enable_done = 1; step(); enable_done = 0;
    eof_error = 1; step(); eof_error = 0;
    chk("R5 error sets change", {30'd0, rd_data[3:2]}, 32'h2);
    write(7'h0C);
    chk("R5 W1C", {31'd0, rd_data[3]}, 32'd0);

    // R6/R7: overcurrent
    enable_done = 1; step(); enable_done = 0;
    oc_sense = 1; step();
    chk("R6 overcurrent disables", {27'd0, rd_data[5:4], 1'b0, rd_data[2]}, 32'h18 >> 1);
    enable_done = 1; step(); enable_done = 0;
    chk("R6 enable blocked under overcurrent", {31'd0, port_enabled}, 32'd0);
    write(7'h24);
    chk("R7 W1C", {31'd0, rd_data[5]}, 32'd0);
    oc_sense = 0; step();
    chk("R7 removal sets change", {31'd0, rd_data[5]}, 32'd1);

    // R9: hardware resume
    jk_detect = 1; step();
    chk("R9 no suspend no effect", {31'd0, drive_resume}, 32'd0);
    suspended = 1; step(); jk_detect = 0;
    chk("R9 hw set", {31'd0, drive_resume}, 32'd1);
    chk("R9 pulse", {31'd0, port_change_pulse}, 32'd1);
    step();
    chk("R9 pulse one cycle", {31'd0, port_change_pulse}, 32'd0);
    // R11: delayed clear
    write(7'h04);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R11 held until idle", {31'd0, drive_resume}, 32'd1);
    end
    hs_idle = 1; step(); hs_idle = 0;
    chk("R11 clears on idle", {31'd0, drive_resume}, 32'd0);
    // R10: software set, no pulse
    suspended = 0;
    write(7'h44);
    chk("R10 sw set", {31'd0, drive_resume}, 32'd1);
    chk("R10 no pulse", {31'd0, port_change_pulse}, 32'd0);
    write(7'h04); hs_idle = 1; step(); hs_idle = 0;

    // random phase
    for (int c = 0; c < 3000; c++) begin
      wr_en = ($urandom % 8) == 0;
      wr_data = {25'd0, 7'($urandom)};
      if (($urandom % 8) != 0) wr_data[2] = 1'b1;
      if (($urandom % 10) == 0) dev_present = ~dev_present;
      if (($urandom % 20) == 0) oc_sense = ~oc_sense;
      if (($urandom % 16) == 0) suspended = ~suspended;
      eof_error = ($urandom % 30) == 0;
      enable_done = ($urandom % 10) == 0;
      jk_detect = ($urandom % 15) == 0;
      hs_idle = ($urandom % 4) == 0;
      step();
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule